// File: doc/BRIEF.md
# Relocatable On-Chip Memory Map Decoder

This block sits between a 16-bit CPU address bus and the on-chip memories. For every address it raises one select among four internal targets: a 1 KB static RAM, a 96-byte control register block, a 512-byte nonvolatile array and a 256-byte boot ROM. When no target claims the address, it raises an external-access flag instead. The decode is combinational. The only state is a mapping byte and the logic that decides when software may change that byte.

The mapping byte picks the 4 KB page of the RAM (high nibble) and the 4 KB page of the register block (low nibble). Software writes it through the register block at a fixed offset. Normal operating modes accept one write, and only within a short window of bus cycles after reset. Special modes accept writes at any time. Targets that share a page resolve by a fixed priority: registers, then RAM, then boot ROM, then the nonvolatile array.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the mapping byte is 0x01. RAM decodes at 0x0000–0x03FF and the register block at 0x1000–0x105F. With the boot ROM and nonvolatile array disabled, addresses outside these two ranges raise only the external flag.
- R2: A write to the mapping byte loads it. A write needs wr_i=1 and bus_tick_i=1 in the same cycle, with an address at offset 0x03D inside the current register page. The high nibble of the written byte becomes the RAM page and the low nibble becomes the register page. The new decode applies from the next cycle.
- R3: The mode encoding is 00 single-chip, 01 expanded, 10 bootstrap and 11 test. Bit 1 set means a special mode. In a normal mode, only the first accepted write changes the mapping byte until the next reset. A write accepted in a special mode also uses up this single normal-mode write.
- R4: A normal-mode write takes effect only if fewer than 64 bus ticks came before it since reset. A saturating counter tracks the ticks. The write on tick 64 is accepted; the write on tick 65 is ignored.
- R5: In special modes every write to the mapping byte takes effect, however many ticks have passed and however many writes came before.
- R6: When RAM and the register block share a page, offsets 0x000–0x05F select the registers. Offsets 0x060–0x3FF select RAM.
- R7: The boot ROM decodes at 0xBF00–0xBFFF only when boot_en_i=1 and the mode is special. Otherwise those addresses fall to lower-priority targets or to the external flag.
- R8: In expanded and test modes the nonvolatile array decodes at offsets 0xE00–0xFFF of the page given by nv_page_i, and only when nv_en_i=1. Where it overlaps the boot ROM, the boot ROM wins.
- R9: In single-chip and bootstrap modes the nonvolatile array decodes at 0xFE00–0xFFFF when nv_en_i=1, and nv_page_i is ignored.
- R10: At most one select is high in any cycle. ext_o is high exactly when no select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | CPU address |
| wr_i | input | 1 | 1 = write cycle |
| bus_tick_i | input | 1 | One-cycle pulse per bus cycle |
| wdata_i | input | 8 | Write data, used by the mapping byte |
| mode_i | input | 2 | Operating mode (00 single-chip, 01 expanded, 10 bootstrap, 11 test) |
| boot_en_i | input | 1 | Boot ROM enable |
| nv_page_i | input | 4 | Page nibble of the nonvolatile array |
| nv_en_i | input | 1 | Nonvolatile array enable |
| sel_reg_o | output | 1 | Register block select |
| sel_ram_o | output | 1 | RAM select |
| sel_boot_o | output | 1 | Boot ROM select |
| sel_nv_o | output | 1 | Nonvolatile array select |
| ext_o | output | 1 | Access goes off-chip |

## Verification
The bench targets the edge of the write window: a normal-mode write on the 64th tick must land, and one on the 65th must not. A counter that is off by one moves the RAM and registers when it should not, or refuses a legal remap. The bench also places RAM and the registers on the same page. A wrong priority either hides the first 96 RAM bytes incorrectly or leaves registers unreachable. It stacks the boot ROM over a nonvolatile page and moves between normal and special modes. These cases expose a boot ROM that ignores its gate, an array that ignores its page nibble in normal modes, and a second normal-mode write that still gets through. Random traffic with occasional resets compares every cycle against a reference model.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = 12;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int NUM_TGT = 4;

    // Target index doubles as priority rank: lower index wins
    localparam int TGT_REG  = 0;
    localparam int TGT_RAM  = 1;
    localparam int TGT_BOOT = 2;
    localparam int TGT_NV   = 3;

    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'b00,
        MODE_EXPANDED  = 2'b01,
        MODE_BOOTSTRAP = 2'b10,
        MODE_TEST      = 2'b11
    } op_mode_t;

    typedef struct packed {
        logic [3:0] ram_page;
        logic [3:0] reg_page;
    } map_t;

    localparam map_t MAP_RESET = '{ram_page: 4'h0, reg_page: 4'h1};

    function automatic logic is_special(op_mode_t m);
        return m[1];
    endfunction

    function automatic logic nv_relocatable(op_mode_t m);
        return m[0];
    endfunction

endpackage

// File: rtl/mmd_map_reg.sv
module mmd_map_reg
    import mmd_pkg::*;
#(
    parameter int WINDOW  = 64,
    parameter int MAP_OFS = 12'h03D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              tick_i,
    input  logic              special_i,
    input  logic [7:0]        wdata_i,
    output map_t              map_o
);

    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             used_q;
    map_t             map_q;
    logic             win_open;
    logic             hit;
    logic             load;

    assign win_open = (cnt_q < CNT_W'(WINDOW));
    assign hit      = (addr_i[ADDR_W-1:PAGE_W] == map_q.reg_page) &&
                      (addr_i[PAGE_W-1:0] == PAGE_W'(MAP_OFS));
    assign load     = tick_i && wr_i && hit &&
                      (special_i || (win_open && !used_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            used_q <= 1'b0;
            map_q  <= MAP_RESET;
        end else begin
            if (tick_i && win_open)
                cnt_q <= cnt_q + 1'b1;
            if (load) begin
                map_q  <= map_t'(wdata_i);
                used_q <= 1'b1;
            end
        end
    end

    assign map_o = map_q;

    // R3: once used, a normal-mode cycle leaves the mapping untouched
    a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
        (used_q && !special_i) |=> $stable(map_q));

    // R4: window closed in a normal mode, mapping frozen
    a_r4_window_closed: assert property (@(posedge clk) disable iff (rst)
        (!win_open && !special_i) |=> $stable(map_q));

    // R4: counter saturates at the window length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(WINDOW));

endmodule

// File: rtl/mmd_region_hits.sv
module mmd_region_hits
    import mmd_pkg::*;
#(
    parameter int RAM_BYTES  = 1024,
    parameter int REG_BYTES  = 96,
    parameter int NV_BYTES   = 512,
    parameter int BOOT_BASE  = 16'hBF00,
    parameter int BOOT_BYTES = 256
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  op_mode_t           mode_i,
    input  logic               boot_en_i,
    input  logic [3:0]         nv_page_i,
    input  logic               nv_en_i,
    input  map_t               map_i,
    output logic [NUM_TGT-1:0] hits_o
);

    localparam int NV_START  = PAGE_BYTES - NV_BYTES;
    localparam int BOOT_LAST = BOOT_BASE + BOOT_BYTES - 1;

    logic [3:0]        page;
    logic [PAGE_W-1:0] ofs;
    logic [3:0]        nv_page_eff;

    assign page        = addr_i[ADDR_W-1:PAGE_W];
    assign ofs         = addr_i[PAGE_W-1:0];
    assign nv_page_eff = nv_relocatable(mode_i) ? nv_page_i : 4'hF;

    always_comb begin
        hits_o           = '0;
        hits_o[TGT_REG]  = (page == map_i.reg_page) && (ofs < PAGE_W'(REG_BYTES));
        hits_o[TGT_RAM]  = (page == map_i.ram_page) && (ofs < PAGE_W'(RAM_BYTES));
        hits_o[TGT_BOOT] = is_special(mode_i) && boot_en_i &&
                           ({1'b0, addr_i} >= 17'(BOOT_BASE)) &&
                           ({1'b0, addr_i} <= 17'(BOOT_LAST));
        hits_o[TGT_NV]   = nv_en_i && (page == nv_page_eff) &&
                           (ofs >= PAGE_W'(NV_START));
    end

endmodule

// File: rtl/mmd_priority.sv
module mmd_priority #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         none_o
);

    for (genvar i = 0; i < N; i++) begin : g_rank
        if (i == 0) begin : g_top
            assign grant_o[i] = req_i[i];
        end else begin : g_lower
            assign grant_o[i] = req_i[i] && !(|req_i[i-1:0]);
        end
    end

    assign none_o = !(|req_i);

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int RAM_BYTES  = 1024,
    parameter int REG_BYTES  = 96,
    parameter int NV_BYTES   = 512,
    parameter int BOOT_BASE  = 16'hBF00,
    parameter int BOOT_BYTES = 256,
    parameter int WINDOW     = 64,
    parameter int MAP_OFS    = 12'h03D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr_i,
    input  logic        wr_i,
    input  logic        bus_tick_i,
    input  logic [7:0]  wdata_i,
    input  logic [1:0]  mode_i,
    input  logic        boot_en_i,
    input  logic [3:0]  nv_page_i,
    input  logic        nv_en_i,
    output logic        sel_reg_o,
    output logic        sel_ram_o,
    output logic        sel_boot_o,
    output logic        sel_nv_o,
    output logic        ext_o
);

    op_mode_t           mode;
    map_t               map;
    logic [NUM_TGT-1:0] hits;
    logic [NUM_TGT-1:0] grant;

    assign mode = op_mode_t'(mode_i);

    mmd_map_reg #(.WINDOW(WINDOW), .MAP_OFS(MAP_OFS)) u_map (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wr_i      (wr_i),
        .tick_i    (bus_tick_i),
        .special_i (is_special(mode)),
        .wdata_i   (wdata_i),
        .map_o     (map)
    );

    mmd_region_hits #(
        .RAM_BYTES (RAM_BYTES),
        .REG_BYTES (REG_BYTES),
        .NV_BYTES  (NV_BYTES),
        .BOOT_BASE (BOOT_BASE),
        .BOOT_BYTES(BOOT_BYTES)
    ) u_hits (
        .addr_i    (addr_i),
        .mode_i    (mode),
        .boot_en_i (boot_en_i),
        .nv_page_i (nv_page_i),
        .nv_en_i   (nv_en_i),
        .map_i     (map),
        .hits_o    (hits)
    );

    mmd_priority #(.N(NUM_TGT)) u_prio (
        .req_i   (hits),
        .grant_o (grant),
        .none_o  (ext_o)
    );

    assign sel_reg_o  = grant[TGT_REG];
    assign sel_ram_o  = grant[TGT_RAM];
    assign sel_boot_o = grant[TGT_BOOT];
    assign sel_nv_o   = grant[TGT_NV];

    // R10: selects are mutually exclusive
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_reg_o, sel_ram_o, sel_boot_o, sel_nv_o}));

    // R10: external flag only when no region claimed the address
    a_r10_ext_none: assert property (@(posedge clk) disable iff (rst)
        ext_o |-> (hits == '0));

    // R6: a register hit is never shadowed
    a_r6_reg_wins: assert property (@(posedge clk) disable iff (rst)
        hits[TGT_REG] |-> sel_reg_o);

    // R7: boot ROM selected only when gated on in a special mode
    a_r7_boot_gate: assert property (@(posedge clk) disable iff (rst)
        sel_boot_o |-> (boot_en_i && mode_i[1]));

endmodule

// File: tb/sim_mem_map_decoder.sv
`timescale 1ns/1ps
module sim_mem_map_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  wdata = '0;
    logic [1:0]  mode = 2'b00;
    logic        boot_en = 1'b0;
    logic [3:0]  nv_page = 4'h0;
    logic        nv_en = 1'b0;
    logic        s_reg, s_ram, s_boot, s_nv, s_ext;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_map;
    logic       m_used;
    int         m_ticks;

    always #2.5 clk = ~clk;

    mem_map_decoder u0 (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .bus_tick_i(tick),
        .wdata_i(wdata), .mode_i(mode), .boot_en_i(boot_en),
        .nv_page_i(nv_page), .nv_en_i(nv_en),
        .sel_reg_o(s_reg), .sel_ram_o(s_ram), .sel_boot_o(s_boot),
        .sel_nv_o(s_nv), .ext_o(s_ext)
    );

    // expected {nv, boot, ram, reg, ext}
    function automatic logic [4:0] expect_vec(logic [15:0] a, logic [1:0] md,
                                              logic be, logic [3:0] np, logic ne,
                                              logic [7:0] mp);
        logic [3:0] pg;
        int off;
        pg  = a[15:12];
        off = int'(a[11:0]);
        if (pg == mp[3:0] && off < 96)                      return 5'b00010;
        if (pg == mp[7:4] && off < 1024)                    return 5'b00100;
        if (md[1] && be && a[15:8] == 8'hBF)                return 5'b01000;
        if (ne && off >= 'hE00 && pg == (md[0] ? np : 4'hF)) return 5'b10000;
        return 5'b00001;
    endfunction

    function automatic string tag_of(logic [4:0] e, logic [1:0] md);
        case (e)
            5'b00010: return "R6";
            5'b00100: return "R1";
            5'b01000: return "R7";
            5'b10000: return md[0] ? "R8" : "R9";
            default:  return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_map = 8'h01; m_used = 1'b0; m_ticks = 0;
    endtask

    task automatic model_edge();
        logic acc;
        acc = tick && wr && addr[15:12] == m_map[3:0] && addr[11:0] == 12'h03D &&
              (mode[1] || (!m_used && m_ticks < 64));
        if (tick && m_ticks < 64) m_ticks++;
        if (acc) begin
            m_map  = wdata;
            m_used = 1'b1;
        end
    endtask

    // drive one cycle, check at the falling edge, then advance the model
    task automatic cyc(input logic [15:0] a, input logic w, input logic t,
                       input logic [7:0] d, input string tag);
        logic [4:0] got, exp;
        @(posedge clk); #1;
        addr = a; wr = w; tick = t; wdata = d;
        @(negedge clk);
        got = {s_nv, s_boot, s_ram, s_reg, s_ext};
        exp = expect_vec(addr, mode, boot_en, nv_page, nv_en, m_map);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h mode=%b actual=%b expected=%b", tag, a, mode, got, exp);
        end
        model_edge();
    endtask

    task automatic look(input logic [15:0] a, input string tag);
        cyc(a, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; wr = 1'b0; tick = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(16'h8000, 1'b0, 1'b1, 8'h00, "R4");
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        model_reset();
        do_reset();

        // R1: reset decode
        look(16'h0000, "R1"); look(16'h03FF, "R1"); look(16'h0400, "R1");
        look(16'h1000, "R1"); look(16'h105F, "R1"); look(16'h1060, "R1");

        // R2 + R6: normal expanded mode, map both to page 2
        mode = 2'b01;
        ticks(10);
        cyc(16'h103D, 1'b1, 1'b1, 8'h22, "R2");
        look(16'h2000, "R6"); look(16'h205F, "R6"); look(16'h2060, "R6");
        look(16'h23FF, "R6"); look(16'h0000, "R2"); look(16'h1000, "R2");
        // R3: second normal write ignored
        cyc(16'h203D, 1'b1, 1'b1, 8'h01, "R3");
        look(16'h2000, "R3"); look(16'h0000, "R3");
        // R2: write without a tick is ignored
        do_reset(); mode = 2'b01;
        cyc(16'h103D, 1'b1, 1'b0, 8'h55, "R2");
        look(16'h5000, "R2"); look(16'h1000, "R2");

        // R4: write on tick 64 accepted
        do_reset(); mode = 2'b00;
        ticks(63);
        cyc(16'h103D, 1'b1, 1'b1, 8'h34, "R4");
        look(16'h3000, "R4"); look(16'h4000, "R4");
        // R4: write on tick 65 rejected
        do_reset(); mode = 2'b00;
        ticks(64);
        cyc(16'h103D, 1'b1, 1'b1, 8'h34, "R4");
        look(16'h1000, "R4"); look(16'h0000, "R4"); look(16'h4000, "R4");

        // R5: special mode, late and repeated writes
        mode = 2'b11;
        cyc(16'h103D, 1'b1, 1'b1, 8'h56, "R5");
        look(16'h6000, "R5"); look(16'h5000, "R5");
        cyc(16'h603D, 1'b1, 1'b1, 8'h78, "R5");
        look(16'h8000, "R5"); look(16'h7000, "R5"); look(16'h6000, "R5");
        cyc(16'h803D, 1'b1, 1'b1, 8'h01, "R5");

        // R7: boot ROM gating
        mode = 2'b10; boot_en = 1'b1;
        look(16'hBF00, "R7"); look(16'hBFFF, "R7"); look(16'hBEFF, "R7");
        boot_en = 1'b0; look(16'hBF00, "R7");
        mode = 2'b00; boot_en = 1'b1; look(16'hBF80, "R7");

        // R8: relocatable array, boot ROM above it
        mode = 2'b11; nv_en = 1'b1; nv_page = 4'hB;
        look(16'hBE00, "R8"); look(16'hBF10, "R8");
        boot_en = 1'b0; look(16'hBF10, "R8");
        mode = 2'b01; nv_page = 4'h5;
        look(16'h5E00, "R8"); look(16'h5FFF, "R8"); look(16'h5DFF, "R8");
        look(16'hFE00, "R8");
        nv_en = 1'b0; look(16'h5E00, "R8");

        // R9: fixed array in single-chip and bootstrap
        nv_en = 1'b1; mode = 2'b00;
        look(16'hFE00, "R9"); look(16'hFFFF, "R9"); look(16'h5E00, "R9");
        mode = 2'b10; look(16'hFF00, "R9"); look(16'hFDFF, "R9");

        // random traffic
        for (int blk = 0; blk < 40; blk++) begin
            if (blk % 8 == 0) do_reset();
            mode    = 2'($urandom_range(0, 3));
            boot_en = 1'($urandom_range(0, 1));
            nv_en   = 1'($urandom_range(0, 1));
            nv_page = 4'($urandom_range(0, 15));
            for (int k = 0; k < 60; k++) begin
                logic [15:0] a;
                logic [11:0] ofs;
                logic [4:0]  e;
                int sel;
                sel = $urandom_range(0, 11);
                case (sel)
                    0: ofs = 12'h000;  1: ofs = 12'h03D;  2: ofs = 12'h05F;
                    3: ofs = 12'h060;  4: ofs = 12'h3FF;  5: ofs = 12'h400;
                    6: ofs = 12'hDFF;  7: ofs = 12'hE00;  8: ofs = 12'hF00;
                    9: ofs = 12'hFFF;  default: ofs = 12'($urandom_range(0, 4095));
                endcase
                a = {4'($urandom_range(0, 15)), ofs};
                if ($urandom_range(0, 9) == 0) begin
                    a = {m_map[3:0], 12'h03D};
                    e = expect_vec(a, mode, boot_en, nv_page, nv_en, m_map);
                    cyc(a, 1'b1, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                        mode[1] ? "R5" : "R3");
                end else begin
                    e = expect_vec(a, mode, boot_en, nv_page, nv_en, m_map);
                    cyc(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        8'h00, tag_of(e, mode));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule